// File: doc/BRIEF.md
# Branch Resolver

The branch resolver decides, for one control-flow instruction per cycle, whether control transfers and to which address. It receives the value of register A, a register value and a 16-bit immediate for operand B, the current program counter, and a decoded descriptor. The descriptor has the following fields:

- instruction kind: none, conditional, jump or return
- condition code
- link flag
- absolute flag
- delay-slot flag
- operand-B source select

The taken decision, the target, the link write and the delay-slot indication are all registered. They appear one cycle after the instruction is presented.

Conditional instructions test register A against zero as a signed value. Jumps are always taken. A jump can form its target relative to the PC or use operand B as an absolute address, and it can also save the current PC for a link register write. Returns are always taken and go to register A plus operand B. Fetch logic uses the taken and slot outputs to decide whether to squash the next sequential instruction.

The registered stage is a two-state machine:

- ST_EMPTY: no result is held.
- ST_FULL: a result is held.

The transitions are:

- ST_EMPTY to ST_FULL (load) when `in_valid` is high.
- ST_FULL to ST_FULL (reload) when `in_valid` is high.
- ST_FULL to ST_EMPTY (drain) when `in_valid` is low.
- ST_EMPTY to ST_EMPTY (idle) when `in_valid` is low.

Top module: `brc_unit`

## Requirements
- R1: For kind conditional (`desc_kind`=1), `taken` reflects a signed 32-bit test of `opa` against zero, selected by `desc_cond`: 0 equal, 1 not equal, 2 less than, 3 less or equal, 4 greater than, 5 greater or equal. Codes 6 and 7 are never taken.
- R2: A taken conditional instruction has target `pc` + operand B.
- R3: Operand B is `opb_reg` when `desc_imm_sel`=0. When `desc_imm_sel`=1, operand B is `imm16` sign-extended to 32 bits.
- R4: A jump (`desc_kind`=2) is always taken. Its target is operand B when `desc_abs`=1 and `pc` + operand B otherwise.
- R5: `link_we` is 1 and `link_val` equals `pc` only for a jump with `desc_link`=1. Otherwise `link_we` and `link_val` are 0.
- R6: A return (`desc_kind`=3) is always taken, with target `opa` + operand B.
- R7: When an instruction is not taken (including kind none, `desc_kind`=0), `target` is `pc`+4 and `taken`, `link_we` and `slot` are 0.
- R8: `slot` equals `desc_slot` AND taken.
- R9: Results appear on the outputs one clock after `in_valid` is high, with `out_valid`=1. A cycle with `in_valid`=0 gives `out_valid`, `taken`, `link_we` and `slot` all 0 on the next cycle.
- R10: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction present this cycle |
| desc_kind | input | 2 | 0 none, 1 conditional, 2 jump, 3 return |
| desc_cond | input | 3 | Condition code (see R1) |
| desc_link | input | 1 | Jump saves PC to link register |
| desc_abs | input | 1 | Jump target is operand B itself |
| desc_slot | input | 1 | Instruction has a delay slot |
| desc_imm_sel | input | 1 | Operand B from immediate |
| opa | input | 32 | Register A value |
| opb_reg | input | 32 | Register B value |
| imm16 | input | 16 | Immediate field |
| pc | input | 32 | Address of the instruction |
| out_valid | output | 1 | Registered result present |
| taken | output | 1 | Control transfers |
| target | output | 32 | Next address |
| link_we | output | 1 | Write link register |
| link_val | output | 32 | Value for link register |
| slot | output | 1 | Next sequential instruction still executes |

## Verification
The properties assume that a result seen with `out_valid` high always comes from the descriptor and operands presented on the previous clock. They also assume that the kind field is one of the four encodings. Because of this, they relate outputs to the inputs one cycle back. The stimulus holds every input steady from just after one rising edge to the next. Random cycles draw register A from a pool that is biased toward zero, plus and minus one, and the two signed extremes, so every comparison boundary is hit. Immediates are chosen with both signs so that sign extension is exercised.

// File: rtl/brc_pkg.sv
package brc_pkg;

    typedef enum logic [2:0] {
        CC_EQ   = 3'd0,
        CC_NE   = 3'd1,
        CC_LT   = 3'd2,
        CC_LE   = 3'd3,
        CC_GT   = 3'd4,
        CC_GE   = 3'd5,
        CC_RSV6 = 3'd6,
        CC_RSV7 = 3'd7
    } brc_cc_e;

    typedef enum logic [1:0] {
        BK_NONE = 2'd0,
        BK_COND = 2'd1,
        BK_JUMP = 2'd2,
        BK_RET  = 2'd3
    } brc_kind_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } brc_state_e;

endpackage

// File: rtl/brc_opsel.sv
module brc_opsel #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input  logic [XLEN-1:0]  opb_reg,
    input  logic [IMM_W-1:0] imm,
    input  logic             imm_sel,
    output logic [XLEN-1:0]  opb_eff
);
    localparam int EXT_W = XLEN - IMM_W;

    logic [XLEN-1:0] imm_ext;

    // Replicate the immediate's top bit across the upper part.
    assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
    assign opb_eff = imm_sel ? imm_ext : opb_reg;
endmodule

// File: rtl/brc_cond.sv
module brc_cond
    import brc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] opa,
    input  brc_cc_e         cc,
    output logic            hit
);
    logic is_zero;
    logic is_neg;

    assign is_zero = (opa == '0);
    assign is_neg  = opa[XLEN-1];

    always_comb begin
        unique case (cc)
            CC_EQ:   hit = is_zero;
            CC_NE:   hit = !is_zero;
            CC_LT:   hit = is_neg;
            CC_LE:   hit = is_neg || is_zero;
            CC_GT:   hit = !is_neg && !is_zero;
            CC_GE:   hit = !is_neg;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/brc_target.sv
module brc_target
    import brc_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int INSN_BYTES = 4
) (
    input  brc_kind_e       kind,
    input  logic            abs_sel,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb_eff,
    output logic [XLEN-1:0] jump_addr,
    output logic [XLEN-1:0] seq_addr
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    logic [XLEN-1:0] pc_rel;
    logic [XLEN-1:0] reg_rel;

    assign pc_rel   = pc + opb_eff;
    assign reg_rel  = opa + opb_eff;
    assign seq_addr = pc + STEP;

    always_comb begin
        unique case (kind)
            BK_JUMP: jump_addr = abs_sel ? opb_eff : pc_rel;
            BK_RET:  jump_addr = reg_rel;
            default: jump_addr = pc_rel;
        endcase
    end
endmodule

// File: rtl/brc_unit.sv
module brc_unit
    import brc_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int IMM_W      = 16,
    parameter int INSN_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       desc_kind,
    input  logic [2:0]       desc_cond,
    input  logic             desc_link,
    input  logic             desc_abs,
    input  logic             desc_slot,
    input  logic             desc_imm_sel,
    input  logic [XLEN-1:0]  opa,
    input  logic [XLEN-1:0]  opb_reg,
    input  logic [IMM_W-1:0] imm16,
    input  logic [XLEN-1:0]  pc,
    output logic             out_valid,
    output logic             taken,
    output logic [XLEN-1:0]  target,
    output logic             link_we,
    output logic [XLEN-1:0]  link_val,
    output logic             slot
);
    brc_kind_e       kind;
    brc_cc_e         cc;
    logic [XLEN-1:0] opb_eff;
    logic            cond_hit;
    logic [XLEN-1:0] jump_addr;
    logic [XLEN-1:0] seq_addr;

    logic            taken_c;
    logic [XLEN-1:0] target_c;
    logic            link_c;
    logic [XLEN-1:0] link_val_c;
    logic            slot_c;

    brc_state_e      state_q;
    brc_state_e      state_d;

    assign kind = brc_kind_e'(desc_kind);
    assign cc   = brc_cc_e'(desc_cond);

    brc_opsel #(.XLEN(XLEN), .IMM_W(IMM_W)) u_opsel (
        .opb_reg (opb_reg),
        .imm     (imm16),
        .imm_sel (desc_imm_sel),
        .opb_eff (opb_eff)
    );

    brc_cond #(.XLEN(XLEN)) u_cond (
        .opa (opa),
        .cc  (cc),
        .hit (cond_hit)
    );

    brc_target #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_target (
        .kind      (kind),
        .abs_sel   (desc_abs),
        .pc        (pc),
        .opa       (opa),
        .opb_eff   (opb_eff),
        .jump_addr (jump_addr),
        .seq_addr  (seq_addr)
    );

    // Decision logic
    always_comb begin
        unique case (kind)
            BK_COND:        taken_c = cond_hit;
            BK_JUMP,
            BK_RET:         taken_c = 1'b1;
            default:        taken_c = 1'b0;
        endcase
        target_c   = taken_c ? jump_addr : seq_addr;
        link_c     = (kind == BK_JUMP) && desc_link;
        link_val_c = link_c ? pc : '0;
        slot_c     = taken_c && desc_slot;
    end

    // Next state
    always_comb begin
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = in_valid ? ST_FULL : ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    assign out_valid = (state_q == ST_FULL);

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taken    <= 1'b0;
            target   <= '0;
            link_we  <= 1'b0;
            link_val <= '0;
            slot     <= 1'b0;
        end else if (in_valid) begin
            taken    <= taken_c;
            target   <= target_c;
            link_we  <= link_c;
            link_val <= link_val_c;
            slot     <= slot_c;
        end else begin
            taken    <= 1'b0;
            link_we  <= 1'b0;
            link_val <= '0;
            slot     <= 1'b0;
        end
    end
endmodule

// File: rtl/brc_unit_chk.sv
module brc_unit_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [1:0]      desc_kind,
    input logic [2:0]      desc_cond,
    input logic            desc_link,
    input logic [XLEN-1:0] opa,
    input logic [XLEN-1:0] pc,
    input logic            out_valid,
    input logic            taken,
    input logic [XLEN-1:0] target,
    input logic            link_we,
    input logic [XLEN-1:0] link_val,
    input logic            slot
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !taken && !link_we && !slot));

    a_r5_link_source: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (taken && $past(desc_kind) == 2'd2 && $past(desc_link)
                     && link_val == $past(pc)));

    a_r8_slot_needs_taken: assert property (@(posedge clk) disable iff (!rst_n)
        slot |-> taken);

    a_r7_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !taken) |-> (target == $past(pc) + STEP));

    a_r6_return_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(desc_kind) == 2'd3) |-> taken);

    a_r1_equal_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(desc_kind) == 2'd1 && $past(desc_cond) == 3'd0)
        |-> (taken == ($past(opa) == '0)));
endmodule

bind brc_unit brc_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .desc_kind (desc_kind),
    .desc_cond (desc_cond),
    .desc_link (desc_link),
    .opa       (opa),
    .pc        (pc),
    .out_valid (out_valid),
    .taken     (taken),
    .target    (target),
    .link_we   (link_we),
    .link_val  (link_val),
    .slot      (slot)
);

// File: tb/brc_unit_bench.sv
module brc_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  desc_kind = '0;
    logic [2:0]  desc_cond = '0;
    logic        desc_link = 1'b0;
    logic        desc_abs = 1'b0;
    logic        desc_slot = 1'b0;
    logic        desc_imm_sel = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb_reg = '0;
    logic [15:0] imm16 = '0;
    logic [31:0] pc = '0;
    logic        out_valid;
    logic        taken;
    logic [31:0] target;
    logic        link_we;
    logic [31:0] link_val;
    logic        slot;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    brc_unit u_brc_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .desc_kind(desc_kind), .desc_cond(desc_cond), .desc_link(desc_link),
        .desc_abs(desc_abs), .desc_slot(desc_slot), .desc_imm_sel(desc_imm_sel),
        .opa(opa), .opb_reg(opb_reg), .imm16(imm16), .pc(pc),
        .out_valid(out_valid), .taken(taken), .target(target),
        .link_we(link_we), .link_val(link_val), .slot(slot)
    );

    function automatic bit exp_cond(input logic [2:0] c, input logic [31:0] a);
        int signed s = $signed(a);
        case (c)
            3'd0: return s == 0;
            3'd1: return s != 0;
            3'd2: return s < 0;
            3'd3: return s <= 0;
            3'd4: return s > 0;
            3'd5: return s >= 0;
            default: return 1'b0;
        endcase
    endfunction

    function automatic void model(output bit e_tk, output logic [31:0] e_tg,
                                  output bit e_lw, output logic [31:0] e_lv,
                                  output bit e_sl);
        logic [31:0] b;
        b = desc_imm_sel ? {{16{imm16[15]}}, imm16} : opb_reg;
        case (desc_kind)
            2'd1: e_tk = exp_cond(desc_cond, opa);
            2'd2, 2'd3: e_tk = 1'b1;
            default: e_tk = 1'b0;
        endcase
        if (!e_tk) e_tg = pc + 32'd4;
        else if (desc_kind == 2'd3) e_tg = opa + b;
        else if (desc_kind == 2'd2 && desc_abs) e_tg = b;
        else e_tg = pc + b;
        e_lw = (desc_kind == 2'd2) && desc_link;
        e_lv = e_lw ? pc : 32'd0;
        e_sl = e_tk && desc_slot;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present inputs now, step one edge, compare registered outputs.
    task automatic step();
        bit e_tk, e_lw, e_sl;
        logic [31:0] e_tg, e_lv;
        bit v;
        string tr, tt;
        v = in_valid;
        model(e_tk, e_tg, e_lw, e_lv, e_sl);
        case (desc_kind)
            2'd1: begin tr = "R1"; tt = desc_imm_sel ? "R3" : "R2"; end
            2'd2: begin tr = "R4"; tt = desc_imm_sel ? "R3" : "R4"; end
            2'd3: begin tr = "R6"; tt = desc_imm_sel ? "R3" : "R6"; end
            default: begin tr = "R7"; tt = "R7"; end
        endcase
        if (!e_tk) tt = "R7";
        @(posedge clk);
        #1;
        chk("R9 valid", {31'd0, out_valid}, {31'd0, v});
        if (v) begin
            chk(tr, {31'd0, taken}, {31'd0, e_tk});
            chk(tt, target, e_tg);
            chk("R5 we", {31'd0, link_we}, {31'd0, e_lw});
            chk("R5 val", link_val, e_lv);
            chk("R8", {31'd0, slot}, {31'd0, e_sl});
        end else begin
            chk("R9 quiet", {28'd0, out_valid, taken, link_we, slot}, 32'd0);
        end
    endtask

    task automatic set(input logic [1:0] k, input logic [2:0] c, input bit lk,
                       input bit ab, input bit sl, input bit is,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic [31:0] p);
        in_valid = 1'b1; desc_kind = k; desc_cond = c; desc_link = lk;
        desc_abs = ab; desc_slot = sl; desc_imm_sel = is;
        opa = a; opb_reg = b; imm16 = im; pc = p;
    endtask

    function automatic logic [31:0] pick_a();
        case ($urandom_range(0, 5))
            0: return 32'd0;
            1: return 32'd1;
            2: return 32'hFFFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'h7FFF_FFFF;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // R10 reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R10", {28'd0, out_valid, taken, link_we, slot}, 32'd0);
        chk("R10 target", target, 32'd0);
        chk("R10 link", link_val, 32'd0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        // R1 every condition at boundary values
        for (int c = 0; c < 8; c++) begin
            set(2'd1, 3'(c), 1'b0, 1'b0, 1'b0, 1'b0, 32'd0, 32'h40, 16'd0, 32'h1000); step();
            set(2'd1, 3'(c), 1'b0, 1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h40, 16'd0, 32'h1000); step();
            set(2'd1, 3'(c), 1'b0, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 32'h40, 16'd0, 32'h1000); step();
            set(2'd1, 3'(c), 1'b0, 1'b0, 1'b1, 1'b0, 32'd1, 32'h40, 16'd0, 32'h1000); step();
        end
        // R3 negative immediate on a conditional
        set(2'd1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 32'd0, 32'h0, 16'hFFF0, 32'h2000); step();
        // R4 absolute jump with link and slot, R5
        set(2'd2, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 32'd5, 32'hABCD_0000, 16'd0, 32'h3000); step();
        // R4 relative jump, negative immediate
        set(2'd2, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 32'd5, 32'd0, 16'h8000, 32'h0001_0000); step();
        // R6 return
        set(2'd3, 3'd0, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0000_5000, 32'd0, 16'd8, 32'h4000); step();
        // R7 kind none with link flag set
        set(2'd0, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 32'd0, 32'h77, 16'd0, 32'h5000); step();
        // R9 idle cycle
        in_valid = 1'b0; step();

        for (int i = 0; i < 3000; i++) begin
            set(2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)),
                1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                pick_a(), $urandom, 16'($urandom), {$urandom} & 32'hFFFF_FFFC);
            in_valid = ($urandom_range(0, 4) != 0);
            step();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule